// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A sixteen-state controller advances on each rising edge of the test clock `tck`. The mode-select input `tms` chooses the next state. A 3-bit instruction register picks one of three data registers and places it between the serial input `tdi` and the serial output `tdo`:

- a 1-bit bypass stage;
- a 32-bit identification register;
- a boundary register, `BND_W` bits wide, whose capture values come from the parallel port `bnd_in`.

Serial data enters at the most significant end of the selected register and leaves from the least significant end. `tdo` and its enable `tdo_en` are registered on the falling edge of `tck`. The enable is high only while a shift state is active.

Test equipment uses the port in a fixed order. It first walks the controller to the instruction path and shifts in an opcode. It then walks to the data path and shifts bits through the register that the opcode selects. The asynchronous reset `trst_n` and a run of five high `tms` samples both put the port in a known idle condition. In that condition the identification register is selected.

Top module: `scan_port_top`

## Requirements
- R1: While `trst_n` is low, the controller is in test-logic-reset, the active instruction is IDCODE (3'b001), and `tdo` and `tdo_en` are both 0.
- R2: Five consecutive rising `tck` edges with `tms`=1 bring the controller to test-logic-reset from any state, and this restores IDCODE as the active instruction.
- R3: On each rising `tck` edge the state moves along the standard sixteen-state graph according to the sampled `tms`. The exit1, pause and exit2 states let a scan stop and then resume shifting where it stopped, with no bits lost.
- R4: `tdo_en` is 1 exactly when the controller is in shift-DR or shift-IR. Otherwise `tdo_en` is 0 and `tdo` is driven 0.
- R5: `tdo` and `tdo_en` change only on falling `tck` edges. During a shift, `tdo` shows the least significant bit of the selected register.
- R6: The instruction register is 3 bits wide and loads 3'b001 in capture-IR, so its first three shifted-out bits are 1, 0, 0.
- R7: Under IDCODE (3'b001), a DR scan shifts out the 32-bit identification value, least significant bit first. Bit 0 of that value is always 1.
- R8: Under BYPASS (3'b111), the selected register is a single stage that captures 0. Its first output bit is 0, and after that `tdo` repeats `tdi` one cycle late.
- R9: Each of the unused codes 3'b011, 3'b100, 3'b101 and 3'b110 selects the bypass stage.
- R10: EXTEST (3'b000) and SAMPLE/PRELOAD (3'b010) both select the `BND_W`-bit boundary register. This register loads `bnd_in` in capture-DR and shifts it out least significant bit first.
- R11: A newly shifted opcode becomes the active instruction only at update-IR. The opcode is the last three bits shifted in, with the latest bit as its most significant bit.
- R12: `tdi` enters the most significant bit of the selected register. After a register's full width has been shifted, the bits taken from `tdi` appear at `tdo` in the order they were applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; inputs sampled on rising edge, outputs driven on falling edge |
| tms | input | 1 | Mode select steering the controller |
| tdi | input | 1 | Serial data into the MSB of the selected register |
| trst_n | input | 1 | Asynchronous active-low reset |
| bnd_in | input | BND_W | Parallel values loaded into the boundary register in capture-DR |
| tdo | output | 1 | Serial data from the LSB of the selected register |
| tdo_en | output | 1 | High while a shift state is active |

## Verification
The hardest state to reach from the ports is a scan that has been paused and then resumed. Showing that no bit is lost or duplicated needs an exact `tms` pattern: exit1, pause held for more than one cycle, exit2, and back to shift. The stimulus uses this pattern in the middle of a boundary scan and in the middle of an instruction scan that is longer than the instruction register. The expected stream is then split across the pause. The longer instruction scan also shows that only the last three bits become the opcode.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b010;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [3:0] {
    TLR, RTI,
    SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } scan_state_e;

  typedef enum logic [1:0] {PATH_BYPASS, PATH_ID, PATH_BND} dr_path_e;

  // Successor state for a sampled mode-select value.
  function automatic scan_state_e scan_next(scan_state_e s, logic tms);
    case (s)
      TLR:     return tms ? TLR    : RTI;
      RTI:     return tms ? SEL_DR : RTI;
      SEL_DR:  return tms ? SEL_IR : CAP_DR;
      CAP_DR:  return tms ? EX1_DR : SH_DR;
      SH_DR:   return tms ? EX1_DR : SH_DR;
      EX1_DR:  return tms ? UPD_DR : PAU_DR;
      PAU_DR:  return tms ? EX2_DR : PAU_DR;
      EX2_DR:  return tms ? UPD_DR : SH_DR;
      UPD_DR:  return tms ? SEL_DR : RTI;
      SEL_IR:  return tms ? TLR    : CAP_IR;
      CAP_IR:  return tms ? EX1_IR : SH_IR;
      SH_IR:   return tms ? EX1_IR : SH_IR;
      EX1_IR:  return tms ? UPD_IR : PAU_IR;
      PAU_IR:  return tms ? EX2_IR : PAU_IR;
      EX2_IR:  return tms ? UPD_IR : SH_IR;
      default: return tms ? SEL_DR : RTI;
    endcase
  endfunction

  // Opcode to data-path decode; unlisted codes fall back to bypass.
  function automatic dr_path_e op_to_path(logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:            return PATH_ID;
      OP_EXTEST, OP_SAMPLE: return PATH_BND;
      default:              return PATH_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
  import scan_port_pkg::*;
(
  input  logic        tck,
  input  logic        trst_n,
  input  logic        tms,
  output scan_state_e st,
  output logic        in_tlr,
  output logic        cap_dr,
  output logic        sh_dr,
  output logic        cap_ir,
  output logic        sh_ir,
  output logic        upd_ir
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= TLR;
    else         st <= scan_next(st, tms);
  end

  assign in_tlr = (st == TLR);
  assign cap_dr = (st == CAP_DR);
  assign sh_dr  = (st == SH_DR);
  assign cap_ir = (st == CAP_IR);
  assign sh_ir  = (st == SH_IR);
  assign upd_ir = (st == UPD_IR);

endmodule

// File: rtl/scan_port_shreg.sv
module scan_port_shreg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tdi,
  input  logic         cap,
  input  logic         sh,
  input  logic [W-1:0] cap_val,
  output logic         lsb
);

  logic [W-1:0] q;

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)  q <= RST_VAL;
        else if (cap) q <= cap_val;
        else if (sh)  q <= tdi;
      end
    end else begin : g_wide
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)  q <= RST_VAL;
        else if (cap) q <= cap_val;
        else if (sh)  q <= {tdi, q[W-1:1]};
      end
    end
  endgenerate

  assign lsb = q[0];

endmodule

// File: rtl/scan_port_ir.sv
module scan_port_ir
  import scan_port_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            cap,
  input  logic            sh,
  input  logic            upd,
  input  logic            tlr,
  output logic            ir_lsb,
  output logic [IR_W-1:0] instr
);

  logic [IR_W-1:0] sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  sr <= IR_CAPTURE;
    else if (cap) sr <= IR_CAPTURE;
    else if (sh)  sr <= {tdi, sr[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  instr <= OP_IDCODE;
    else if (tlr) instr <= OP_IDCODE;
    else if (upd) instr <= sr;
  end

  assign ir_lsb = sr[0];

endmodule

// File: rtl/scan_port_dr.sv
module scan_port_dr
  import scan_port_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h0C3A_5069,
  parameter int          BND_W    = 16
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  logic             cap,
  input  logic             sh,
  input  dr_path_e         path,
  input  logic [BND_W-1:0] bnd_in,
  output logic             dr_lsb
);

  localparam logic [31:0] ID_EFF = {ID_VALUE[31:1], 1'b1};

  logic byp_lsb, id_lsb, bnd_lsb;
  logic use_byp, use_id, use_bnd;

  assign use_byp = (path == PATH_BYPASS);
  assign use_id  = (path == PATH_ID);
  assign use_bnd = (path == PATH_BND);

  scan_port_shreg #(.W(1), .RST_VAL(1'b0)) byp_i (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .cap(cap && use_byp), .sh(sh && use_byp),
    .cap_val(1'b0), .lsb(byp_lsb)
  );

  scan_port_shreg #(.W(32), .RST_VAL(ID_EFF)) id_i (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .cap(cap && use_id), .sh(sh && use_id),
    .cap_val(ID_EFF), .lsb(id_lsb)
  );

  scan_port_shreg #(.W(BND_W), .RST_VAL('0)) bnd_i (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .cap(cap && use_bnd), .sh(sh && use_bnd),
    .cap_val(bnd_in), .lsb(bnd_lsb)
  );

  always_comb begin
    case (path)
      PATH_ID:  dr_lsb = id_lsb;
      PATH_BND: dr_lsb = bnd_lsb;
      default:  dr_lsb = byp_lsb;
    endcase
  end

endmodule

// File: rtl/scan_port_top.sv
module scan_port_top
  import scan_port_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h0C3A_5069,
  parameter int          BND_W    = 16
) (
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic             trst_n,
  input  logic [BND_W-1:0] bnd_in,
  output logic             tdo,
  output logic             tdo_en
);

  scan_state_e     st;
  logic            in_tlr, cap_dr, sh_dr, cap_ir, sh_ir, upd_ir;
  logic            ir_lsb, dr_lsb;
  logic [IR_W-1:0] instr_act;
  dr_path_e        path;

  scan_port_fsm fsm_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st(st),
    .in_tlr(in_tlr), .cap_dr(cap_dr), .sh_dr(sh_dr),
    .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir)
  );

  scan_port_ir ir_i (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .cap(cap_ir), .sh(sh_ir), .upd(upd_ir), .tlr(in_tlr),
    .ir_lsb(ir_lsb), .instr(instr_act)
  );

  assign path = op_to_path(instr_act);

  scan_port_dr #(.ID_VALUE(ID_VALUE), .BND_W(BND_W)) dr_i (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .cap(cap_dr), .sh(sh_dr), .path(path),
    .bnd_in(bnd_in), .dr_lsb(dr_lsb)
  );

  // Output stage on the falling edge, half a cycle after the shift.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= sh_dr | sh_ir;
      tdo    <= sh_ir ? ir_lsb : (sh_dr ? dr_lsb : 1'b0);
    end
  end

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_port_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input scan_state_e     st,
  input logic [IR_W-1:0] instr,
  input logic            tdo,
  input logic            tdo_en
);

  logic [2:0] ones;
  logic       tdo_pos;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          ones <= 3'd0;
    else if (!tms)        ones <= 3'd0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  // Value of tdo just before each rising edge.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) tdo_pos <= 1'b0;
    else         tdo_pos <= tdo;
  end

  assert_tlr_idcode_R1: assert property (@(posedge tck) disable iff (!trst_n)
    st == TLR |=> instr == OP_IDCODE);

  assert_five_ones_reset_R2: assert property (@(posedge tck) disable iff (!trst_n)
    ones == 3'd5 |-> st == TLR);

  assert_leave_tlr_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (st == TLR && !tms) |=> st == RTI);

  assert_oe_shift_only_R4: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (st == SH_DR || st == SH_IR));

  assert_tdo_falling_only_R5: assert property (@(negedge tck) disable iff (!trst_n)
    tdo == tdo_pos);

  assert_instr_update_only_R11: assert property (@(posedge tck) disable iff (!trst_n)
    (st != UPD_IR && st != TLR) |=> $stable(instr));

endmodule

bind scan_port_top scan_port_chk chk_i (
  .tck(tck), .trst_n(trst_n), .tms(tms), .st(st),
  .instr(instr_act), .tdo(tdo), .tdo_en(tdo_en)
);

// File: tb/scan_port_top_tb_top.sv
module scan_port_top_tb_top;

  localparam logic [31:0] ID = 32'h0C3A_5069;
  localparam int          BW = 16;

  logic          tck = 1'b0;
  logic          tms, tdi, trst_n;
  logic [BW-1:0] bnd_in;
  wire           tdo, tdo_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit watch_pos = 0;
  logic last_tdo;

  typedef struct {
    logic  en;
    logic  bitv;
    bit    chk;
    string req;
  } exp_t;
  exp_t exp_q[$];

  scan_port_top dut_i (
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n),
    .bnd_in(bnd_in), .tdo(tdo), .tdo_en(tdo_en)
  );

  always #5 tck = ~tck;

  task automatic push(input logic en, input logic b, input bit chk, input string req);
    exp_t e;
    e.en = en; e.bitv = b; e.chk = chk; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: compares each falling-edge output with the next expected item.
  always @(negedge tck) begin
    exp_t e;
    #2;
    last_tdo = tdo;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_chk++;
      if (tdo_en !== e.en || (e.chk && tdo !== e.bitv)) begin
        n_fail++;
        $display("FAIL %s: tdo_en=%b tdo=%b expected tdo_en=%b tdo=%b",
                 e.req, tdo_en, tdo, e.en, e.chk ? e.bitv : tdo);
      end
    end
  end

  // R5: tdo must not move at a rising edge.
  always @(posedge tck) begin
    #1;
    if (watch_pos) begin
      n_chk++;
      if (tdo !== last_tdo) begin
        n_fail++;
        $display("FAIL R5: tdo=%b after rising edge expected %b", tdo, last_tdo);
      end
    end
  end

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  // Scan from run-test/idle and back; optional pause after bit pause_at.
  task automatic scan(input bit is_ir, input int n, input logic [63:0] din,
                      input logic [63:0] dexp, input int pause_at, input string req);
    step(1, 0);
    if (is_ir) step(1, 0);
    step(0, 0);
    step(0, 0);
    for (int i = 0; i < n; i++) begin
      push(1'b1, dexp[i], 1'b1, req);
      step((i == n-1) || (i == pause_at), din[i]);
      if (i == pause_at && i != n-1) begin
        push(1'b0, 1'b0, 1'b1, {req, "/R4"}); step(0, 0);
        push(1'b0, 1'b0, 1'b1, {req, "/R4"}); step(0, 0);
        push(1'b0, 1'b0, 1'b1, {req, "/R3"}); step(1, 0);
        push(1'b0, 1'b0, 1'b1, {req, "/R3"}); step(0, 0);
      end
    end
    push(1'b0, 1'b0, 1'b1, "R4");
    step(1, 0);
    step(0, 0);
  endtask

  function automatic logic [63:0] byp_exp(input logic [63:0] d);
    return {d[62:0], 1'b0};
  endfunction

  function automatic logic [63:0] bnd_exp(input logic [BW-1:0] b, input logic [63:0] d);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) r[i] = (i < BW) ? b[i] : d[i-BW];
    return r;
  endfunction

  task automatic load_ir(input logic [2:0] op);
    scan(1, 3, {61'b0, op}, 64'b001, -1, "R6");
  endtask

  initial begin
    tms = 1'b1; tdi = 1'b0; trst_n = 1'b0; bnd_in = 16'hA5C3;
    #23 trst_n = 1'b1;

    // R1: state after reset
    @(negedge tck); #3;
    n_chk++;
    if (tdo_en !== 1'b0 || tdo !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: tdo_en=%b tdo=%b expected 0 0", tdo_en, tdo);
    end
    step(1, 0); step(1, 0); step(0, 0);

    // R1/R7: identification value after reset, with R5 edge watch
    watch_pos = 1;
    scan(0, 32, 64'h0, {32'b0, ID[31:1], 1'b1}, -1, "R1/R7");
    watch_pos = 0;

    // R6 + R8: bypass
    load_ir(3'b111);
    scan(0, 8, 64'hB2, byp_exp(64'hB2), -1, "R8");

    // R9: unused codes
    load_ir(3'b011);
    scan(0, 6, 64'h2D, byp_exp(64'h2D), -1, "R9");
    load_ir(3'b110);
    scan(0, 6, 64'h13, byp_exp(64'h13), -1, "R9");

    // R10/R12: SAMPLE, boundary capture then tdi data
    load_ir(3'b010);
    scan(0, BW+4, 64'h9_0000, bnd_exp(16'hA5C3, 64'h9_0000), -1, "R10/R12");

    // R10/R3: EXTEST with a pause mid-scan
    load_ir(3'b000);
    bnd_in = 16'h3C96;
    scan(0, BW+4, 64'h6_0000, bnd_exp(16'h3C96, 64'h6_0000), 7, "R10/R3");

    // R11/R12: 5-bit instruction scan with pause; last three bits 111 -> bypass
    load_ir(3'b001);
    scan(1, 5, 64'b11101, 64'b01001, 1, "R11/R12");
    scan(0, 6, 64'h35, byp_exp(64'h35), -1, "R11");

    // R2: five ones from shift-DR return to reset and IDCODE
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 5; k++) step(1, 0);
    push(1'b0, 1'b0, 1'b1, "R2");
    step(0, 0);
    scan(0, 32, 64'h0, {32'b0, ID[31:1], 1'b1}, -1, "R2");

    step(0, 0); step(0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1: run still active, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule